// File: doc/BRIEF.md
# Cache Capacity Allocation Controller

This block keeps, for every resource-control ID (RCID) and access type, a mask of the capacity blocks of a shared cache that the ID is allowed to fill. Software works through a small window of 64-bit registers. It places a block mask in a staging register. It then writes a command register holding an operation code, an RCID, an access type and a flag that says whether the access type is meaningful. The controller validates the request in a fixed order and records a status code. It then copies the staged mask into its table, copies a stored mask back into the staging register, or leaves everything as it is.

After each accepted command a busy flag stays high for a fixed number of cycles. Further commands are dropped while it is high. Every register can be written as a whole word or one 32-bit half at a time. Reset clears the command register, the busy flag and the staging mask. The table itself is plain RAM and keeps whatever it held before reset.

Top module: `qos_cap_alloc_ctrl`

## Requirements
- R1: After reset the command word (offset 0x000) reads zero, with busy and status both 0, and the staging mask (offset 0x008) reads zero.
- R2: The command word layout is op in bits [4:0], access type in [7:5], type-valid flag in bit 8, RCID in [20:9], status in [38:32] and busy in bit 39. Op 1 (store) copies the staging mask into the table entry for (RCID, type) and reports status 1.
- R3: Op 2 (load) copies the table entry for (RCID, type) into the staging mask and reports status 1.
- R4: An RCID at or above NRCID gives status 3 and leaves the table unchanged. This check comes before every other check.
- R5: Type code 0 is data and 1 is code. When the valid flag is set and the type is above 1, the status is 4. When the flag is clear the type field is ignored and the data entry is used.
- R6: Op 3 (flush) reports status 1 and changes neither the table nor the staging mask.
- R7: Any other op code (0, or 4 to 31) reports status 2 and leaves the table unchanged.
- R8: Busy rises on the edge that accepts a command and stays high for BUSY_CYC cycles. Command writes that arrive while busy is high are dropped.
- R9: Write select bit 0 enables the low 32 bits of a write and bit 1 enables the high 32 bits. A command is launched only by a write whose bit 0 is set. The status and busy half of the command word is read-only.
- R10: Mask bits at or above NBLK read as zero. The capacity-units word, which sits right after the last mask slot, reads zero and ignores writes. Unmapped offsets read zero.
- R11: Read data is registered and appears in the cycle after the one in which rd_en is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte offset in the window; bits [2:0] are ignored |
| wsel | input | 2 | 32-bit half enables for writes (bit 0 low, bit 1 high) |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Registered read data |

## Verification
The assertions assume that rd_en and wr_en are never both high in the same cycle and that addresses are 8-byte aligned. They also assume software does not write the staging mask while a load command is still busy. The bench drives one bus operation at a time. It waits out the busy window before it touches the staging register again. Random commands are drawn from the legal op codes together with a few reserved ones, and the RCIDs run slightly past NRCID. This covers every rejection path without breaking those assumptions.

// File: rtl/qca_pkg.sv
package qca_pkg;
  localparam int OP_LSB   = 0;
  localparam int AT_LSB   = 5;
  localparam int ATV_BIT  = 8;
  localparam int RCID_LSB = 9;
  localparam int ST_LSB   = 32;
  localparam int BUSY_BIT = 39;

  typedef enum logic [4:0] {
    OP_STORE = 5'd1,
    OP_LOAD  = 5'd2,
    OP_FLUSH = 5'd3
  } op_e;

  typedef enum logic [6:0] {
    ST_IDLE    = 7'd0,
    ST_OK      = 7'd1,
    ST_BAD_OP  = 7'd2,
    ST_BAD_ID  = 7'd3,
    ST_BAD_AT  = 7'd4
  } status_e;

  localparam logic [2:0] AT_DATA = 3'd0;
  localparam logic [2:0] AT_CODE = 3'd1;
endpackage

// File: rtl/qca_req_check.sv
module qca_req_check
  import qca_pkg::*;
#(
  parameter int RCID_W = 12,
  parameter int NRCID  = 16
) (
  input  logic [4:0]        op,
  input  logic [2:0]        at,
  input  logic              atv,
  input  logic [RCID_W-1:0] rcid,
  output logic [6:0]        status,
  output logic              do_store,
  output logic              do_load
);
  logic id_bad;
  logic at_bad;

  always_comb begin
    id_bad   = ({1'b0, rcid} >= (RCID_W+1)'(NRCID));
    at_bad   = atv && (at != AT_DATA) && (at != AT_CODE);
    do_store = 1'b0;
    do_load  = 1'b0;
    if (id_bad) begin
      status = ST_BAD_ID;
    end else if (at_bad) begin
      status = ST_BAD_AT;
    end else begin
      case (op)
        OP_STORE: begin status = ST_OK; do_store = 1'b1; end
        OP_LOAD:  begin status = ST_OK; do_load  = 1'b1; end
        OP_FLUSH: status = ST_OK;
        default:  status = ST_BAD_OP;
      endcase
    end
  end
endmodule

// File: rtl/qca_mask_table.sv
module qca_mask_table #(
  parameter int W     = 64,
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/qca_busy_timer.sv
module qca_busy_timer #(
  parameter int BUSY_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= CW'(BUSY_CYC - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/qos_cap_alloc_ctrl.sv
module qos_cap_alloc_ctrl
  import qca_pkg::*;
#(
  parameter int NBLK     = 48,
  parameter int NRCID    = 16,
  parameter int RCID_W   = 12,
  parameter int BUSY_CYC = 4,
  parameter int ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        wsel,
  input  logic [63:0]       wdata,
  output logic [63:0]       rdata
);
  localparam int BMW    = ((NBLK + 63) / 64) * 64;
  localparam int NSLOT  = BMW / 64;
  localparam int RIDX_W = $clog2(NRCID);
  localparam int IDX_W  = RIDX_W + 1;
  localparam int DEPTH  = NRCID * 2;
  localparam int WORD_W = ADDR_W - 3;
  localparam logic [BMW-1:0] PAD = (BMW'(1) << NBLK) - BMW'(1);

  logic [WORD_W-1:0] word;
  assign word = addr[ADDR_W-1:3];

  // incoming command fields
  logic [4:0]        op_in;
  logic [2:0]        at_in;
  logic              atv_in;
  logic [RCID_W-1:0] rcid_in;
  assign op_in   = wdata[OP_LSB +: 5];
  assign at_in   = wdata[AT_LSB +: 3];
  assign atv_in  = wdata[ATV_BIT];
  assign rcid_in = wdata[RCID_LSB +: RCID_W];

  logic busy;
  logic ctl_wr, launch;
  assign ctl_wr = wr_en && wsel[0] && (word == '0);
  assign launch = ctl_wr && !busy;

  logic [6:0] status_n;
  logic       do_store, do_load;

  qca_req_check #(.RCID_W(RCID_W), .NRCID(NRCID)) u_check (
    .op(op_in), .at(at_in), .atv(atv_in), .rcid(rcid_in),
    .status(status_n), .do_store(do_store), .do_load(do_load)
  );

  qca_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk(clk), .rst(rst), .start(launch), .busy(busy)
  );

  logic [IDX_W-1:0] idx;
  assign idx = {rcid_in[RIDX_W-1:0], atv_in ? at_in[0] : 1'b0};

  logic [BMW-1:0] stage;
  logic [BMW-1:0] tab_q;
  logic           tab_we;
  assign tab_we = launch && do_store;

  qca_mask_table #(.W(BMW), .DEPTH(DEPTH), .AW(IDX_W)) u_table (
    .clk(clk), .we(tab_we), .waddr(idx), .wdata(stage),
    .raddr(idx), .rdata(tab_q)
  );

  // command register state
  logic [4:0]        op_q;
  logic [2:0]        at_q;
  logic              atv_q;
  logic [RCID_W-1:0] rcid_q;
  logic [6:0]        status_q;
  logic              load_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q      <= '0;
      at_q      <= '0;
      atv_q     <= 1'b0;
      rcid_q    <= '0;
      status_q  <= ST_IDLE;
      load_pend <= 1'b0;
    end else begin
      load_pend <= launch && do_load;
      if (launch) begin
        op_q     <= op_in;
        at_q     <= at_in;
        atv_q    <= atv_in;
        rcid_q   <= rcid_in;
        status_q <= status_n;
      end
    end
  end

  // staging mask, written per 32-bit half, pad bits forced low
  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        if (wr_en && (word == WORD_W'(s + 1))) begin
          if (wsel[0]) stage[s*64 +: 32] <= wdata[31:0] & PAD[s*64 +: 32];
          if (wsel[1]) stage[s*64+32 +: 32] <= wdata[63:32] & PAD[s*64+32 +: 32];
        end
      end
      if (load_pend) stage <= tab_q & PAD;
    end
  end

  // read mux
  logic [63:0] ctl_word;
  logic [63:0] rd_mux;

  always_comb begin
    ctl_word = '0;
    ctl_word[OP_LSB +: 5]       = op_q;
    ctl_word[AT_LSB +: 3]       = at_q;
    ctl_word[ATV_BIT]           = atv_q;
    ctl_word[RCID_LSB +: RCID_W] = rcid_q;
    ctl_word[ST_LSB +: 7]       = status_q;
    ctl_word[BUSY_BIT]          = busy;
  end

  always_comb begin
    rd_mux = '0;
    if (word == '0) rd_mux = ctl_word;
    for (int s = 0; s < NSLOT; s++) begin
      if (word == WORD_W'(s + 1)) rd_mux = stage[s*64 +: 64];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R8
  launch_busy_chk: assert property (@(posedge clk) disable iff (rst)
    launch |=> busy);

  // R8
  busy_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && ctl_wr) |=> ($stable(op_q) && $stable(rcid_q) && $stable(status_q)));

  // R4
  bad_rcid_chk: assert property (@(posedge clk) disable iff (rst)
    (launch && ({1'b0, rcid_in} >= (RCID_W+1)'(NRCID))) |=> (status_q == ST_BAD_ID));

  // R5
  bad_at_chk: assert property (@(posedge clk) disable iff (rst)
    (launch && ({1'b0, rcid_in} < (RCID_W+1)'(NRCID)) && atv_in && (at_in > 3'd1))
      |=> (status_q == ST_BAD_AT));

  // R6
  no_table_write_chk: assert property (@(posedge clk) disable iff (rst)
    (launch && (op_in != OP_STORE)) |-> !tab_we);
endmodule

// File: tb/qos_cap_alloc_ctrl_test.sv
module qos_cap_alloc_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NBLK = 48;
  localparam int NRCID = 16;
  localparam int BUSY_CYC = 4;
  localparam logic [63:0] PAD = (64'd1 << NBLK) - 64'd1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0] wsel = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic [63:0] model [NRCID*2];

  always #(CLK_PERIOD/2) clk = ~clk;

  qos_cap_alloc_ctrl #(.NBLK(NBLK), .NRCID(NRCID), .RCID_W(12),
    .BUSY_CYC(BUSY_CYC), .ADDR_W(12)) uut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wsel(wsel), .wdata(wdata), .rdata(rdata));

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d, input logic [1:0] s);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; wsel = s;
    @(negedge clk);
    wr_en = 1'b0; wsel = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  function automatic logic [63:0] cmd(input int op, input int at, input bit atv, input int rcid);
    return (64'(rcid) << 9) | (64'(atv) << 8) | (64'(at & 7) << 5) | 64'(op & 31);
  endfunction

  function automatic int exp_status(input int op, input int at, input bit atv, input int rcid);
    if (rcid >= NRCID) return 3;
    if (atv && at > 1) return 4;
    if (op >= 1 && op <= 3) return 1;
    return 2;
  endfunction

  // issue command, wait out busy, return command word
  task automatic do_cmd(input int op, input int at, input bit atv, input int rcid,
                        output logic [63:0] ctl);
    wr(12'h000, cmd(op, at, atv, rcid), 2'b01);
    repeat (BUSY_CYC + 1) @(negedge clk);
    rd(12'h000, ctl);
  endtask

  // full command with model update and checks
  task automatic run(input string req, input int op, input int at, input bit atv,
                     input int rcid, input logic [63:0] stage_v);
    logic [63:0] ctl, m;
    int st, ix;
    logic [63:0] exp_stage;
    st = exp_status(op, at, atv, rcid);
    ix = rcid * 2 + (atv ? (at & 1) : 0);
    exp_stage = stage_v & PAD;
    if (st == 1 && op == 1) model[ix] = exp_stage;
    if (st == 1 && op == 2) exp_stage = model[ix];
    do_cmd(op, at, atv, rcid, ctl);
    check(req, ctl, cmd(op, at, atv, rcid) | (64'(st) << 32));
    rd(12'h008, m);
    check(req, m, exp_stage);
  endtask

  task automatic stage_set(input logic [63:0] v);
    wr(12'h008, v, 2'b11);
  endtask

  initial begin
    logic [63:0] d;
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(12'h000, d); check("R1 ctl", d, 64'h0);
    rd(12'h008, d); check("R1 mask", d, 64'h0);

    // R10 padding, capacity units, unmapped
    stage_set(64'hFFFF_FFFF_FFFF_FFFF);
    rd(12'h008, d); check("R10 pad", d, PAD);
    wr(12'h010, 64'h1234, 2'b11);
    rd(12'h010, d); check("R10 cunits", d, 64'h0);
    rd(12'h800, d); check("R10 unmapped", d, 64'h0);

    // R9 half writes
    stage_set(64'h0);
    wr(12'h008, 64'hFFFF_FFFF_FFFF_FFFF, 2'b10);
    rd(12'h008, d); check("R9 high half", d, 64'h0000_FFFF_0000_0000);
    wr(12'h008, 64'hAAAA_AAAA_1234_5678, 2'b01);
    rd(12'h008, d); check("R9 low half", d, 64'h0000_FFFF_1234_5678);
    wr(12'h000, cmd(1, 0, 1'b0, 0), 2'b10);
    rd(12'h000, d); check("R9 no launch", d, 64'h0);

    // R2 fill table
    for (int r = 0; r < NRCID; r++) begin
      for (int a = 0; a < 2; a++) begin
        v = {32'(r * 977 + a * 31), 32'(32'hC0DE0000 + r * 2 + a)};
        stage_set(v);
        run("R2 store", 1, a, 1'b1, r, v);
      end
    end

    // R3 load, R5 flag-clear uses data entry
    stage_set(64'h0);
    run("R3 load", 2, 1, 1'b1, 5, 64'h0);
    run("R5 atv clear", 2, 1, 1'b0, 5, 64'h0);

    // R4 bad rcid, aliasing entry stays intact
    stage_set(64'h0000_1111_2222_3333);
    run("R4 bad id", 1, 0, 1'b1, NRCID, 64'h0000_1111_2222_3333);
    run("R4 table kept", 2, 0, 1'b1, 0, 64'h0000_1111_2222_3333);

    // R5 bad type and ordering against bad rcid
    stage_set(64'h55);
    run("R5 bad at", 1, 3, 1'b1, 2, 64'h55);
    run("R5 order", 1, 3, 1'b1, NRCID + 4, 64'h55);
    run("R5 table kept", 2, 0, 1'b1, 2, 64'h55);

    // R6 flush
    stage_set(64'h0000_BEEF_0000_CAFE);
    run("R6 flush", 3, 1, 1'b1, 3, 64'h0000_BEEF_0000_CAFE);
    run("R6 table kept", 2, 1, 1'b1, 3, 64'h0);

    // R7 unsupported ops
    stage_set(64'h77);
    run("R7 op0", 0, 0, 1'b1, 4, 64'h77);
    run("R7 op9", 9, 0, 1'b1, 4, 64'h77);
    run("R7 table kept", 2, 0, 1'b1, 4, 64'h0);

    // R8 / R11 busy window and dropped command
    wr(12'h000, cmd(2, 0, 1'b1, 6), 2'b01);
    rd(12'h000, d);
    check("R8 busy high", d[39], 1'b1);
    wr(12'h000, cmd(1, 1, 1'b1, 7), 2'b01);
    repeat (BUSY_CYC + 1) @(negedge clk);
    rd(12'h000, d);
    check("R8 dropped", d, cmd(2, 0, 1'b1, 6) | (64'd1 << 32));
    rd(12'h008, d);
    check("R11 load data", d, model[12]);

    // random mix
    for (int i = 0; i < 200; i++) begin
      int op, at, rc;
      bit atv;
      logic [63:0] sv;
      op = ($urandom % 5 == 0) ? int'($urandom % 32) : int'(1 + $urandom % 3);
      at = $urandom % 4;
      atv = 1'($urandom % 4 != 0);
      rc = $urandom % (NRCID + 3);
      sv = {$urandom, $urandom};
      stage_set(sv);
      run("R2 random", op, at, atv, rc, sv);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule